// File: doc/BRIEF.md
# Vector Coprocessor Control Transfer Unit

This block connects a host integer CPU to a vector coprocessor. It carries out four kinds of transfer. A 128-bit move copies a host value into a vector register. A 128-bit move copies a vector register back to the host. A 32-bit read fetches a control register, and a 32-bit write stores one. The host presents each transfer with a valid/ready handshake. Transfers that return data do so one cycle after acceptance, together with the host destination register and a write-enable.

A transfer can ask for an interlock. In that case the unit holds `req_ready` low until the coprocessor reports that its microprogram has stopped. Writes to control registers pass through a filter:

- Some registers are read-only.
- The break/reset register keeps only a masked set of bits and turns other bits into one-cycle break and reset pulses.
- A write to the second unit's start register launches that unit's microprogram, unless the unit is already busy.

The block also outputs the coprocessor branch condition and the branch decision. It computes the byte address of a microprogram call from an instruction word.

Top module: `vcx_xfer_unit`

## Requirements
- R1: After synchronous reset, `rsp_valid`, all pulse outputs and `u1_pc` are 0, `req_ready` is 1, and every vector and control register reads back 0.
- R2: Operation codes on `req_op`: 0 writes `req_data` into vector register `req_idx`; 1 reads vector register `req_idx`; 2 reads control register `req_idx`; 3 writes `req_data[31:0]` into control register `req_idx`. Reads raise `rsp_valid` for exactly the cycle after acceptance, with `rsp_hreg` equal to the accepted `req_hreg`.
- R3: When `req_wait` is 1 and `u0_run` (status bit 0) is 1, `req_ready` is 0 and nothing is accepted. Once `u0_run` clears, the transfer is accepted. When `req_wait` is 0, `u0_run` does not delay the transfer.
- R4: A control read returns the register in `rsp_data[31:0]`, copies of bit 31 in `rsp_data[63:32]`, and zeros in `rsp_data[127:64]`.
- R5: Index 0 is never a valid destination. A vector write to index 0 and a control write to index 0 change nothing, and any read of index 0 returns 0. A read with `req_hreg` = 0 gives `rsp_wen` = 0; any other `req_hreg` gives `rsp_wen` = 1.
- R6: Writes to control index 16 (arithmetic flags), 26 (program counter) and 29 (status) are ignored. Index 29 reads as `u0_run` in bit 0 and `u1_run` in bit 8, with all other bits 0.
- R7: A write to control index 28 (break/reset) stores `req_data & 32'h0000_0C0C`.
- R8: In the same write to index 28, data bit 0 pulses `u0_break`, bit 1 pulses `u0_reset`, bit 8 pulses `u1_break` and bit 9 pulses `u1_reset`. Each pulse lasts one cycle and starts the cycle after acceptance.
- R9: A write to control index 31 (unit-1 start) loads `req_data[15:0]` into `u1_pc` and pulses `u1_start` for one cycle, but only if `u1_run` is 0 at acceptance. Otherwise `u1_pc` is unchanged and there is no pulse. Index 31 is not stored and reads 0.
- R10: A control write to any other nonzero index stores all 32 bits unchanged.
- R11: `cop_cond` equals `u1_run` (status bit 8). `br_taken` is 1 when `cop_cond` equals `br_on_true`, so the branch-on-false form tests for 0 and the branch-on-true form tests for 1.
- R12: `call_addr` equals `call_instr[20:6]` multiplied by 8, which is 18 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request present |
| req_ready | output | 1 | Request accepted this cycle when high with valid |
| req_op | input | 2 | Transfer kind (see R2) |
| req_wait | input | 1 | Interlock on coprocessor running |
| req_idx | input | 5 | Coprocessor-side register index |
| req_hreg | input | 5 | Host destination register for reads |
| req_data | input | 128 | Write data (control writes use bits 31:0) |
| rsp_valid | output | 1 | Read result present |
| rsp_wen | output | 1 | Host register write enable |
| rsp_hreg | output | 5 | Host destination register |
| rsp_data | output | 128 | Read result |
| u0_run | input | 1 | Unit 0 microprogram running |
| u1_run | input | 1 | Unit 1 busy |
| u0_break | output | 1 | Force-break pulse, unit 0 |
| u0_reset | output | 1 | Reset pulse, unit 0 |
| u1_break | output | 1 | Force-break pulse, unit 1 |
| u1_reset | output | 1 | Reset pulse, unit 1 |
| u1_start | output | 1 | Unit 1 microprogram start pulse |
| u1_pc | output | 16 | Unit 1 start program counter |
| br_on_true | input | 1 | Branch form: 1 = on true, 0 = on false |
| cop_cond | output | 1 | Coprocessor branch condition |
| br_taken | output | 1 | Branch decision |
| call_instr | input | 32 | Microprogram call instruction |
| call_addr | output | 18 | Microprogram call byte address |

## Verification
The 128-bit moves are tried with all-ones, alternating and distinct per-register patterns, so a lane mix-up or an index alias shows up. Control reads use values with bit 31 set and with bit 31 clear, which separates sign fill from zero fill. Break/reset writes use all-ones and single-bit data, which shows whether the mask and each pulse bit are decoded separately. The interlock is tried with the running bit held for several cycles, both with and without the wait flag. Start writes are tried with the second unit idle and busy.

// File: rtl/vcx_pkg.sv
package vcx_pkg;
  typedef enum logic [1:0] {
    OP_VEC_WR = 2'd0,
    OP_VEC_RD = 2'd1,
    OP_CTL_RD = 2'd2,
    OP_CTL_WR = 2'd3
  } xfer_op_e;

  // 32-bit control value widened to 64 bits with its sign bit copied upward
  function automatic logic [63:0] widen_signed(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // microprogram call byte address: 15-bit field at bits 20:6, times 8
  function automatic logic [17:0] call_target(input logic [31:0] instr);
    return {instr[20:6], 3'b000};
  endfunction

  function automatic logic is_read(input xfer_op_e op);
    return (op == OP_VEC_RD) || (op == OP_CTL_RD);
  endfunction
endpackage

// File: rtl/vcx_interlock.sv
module vcx_interlock (
  input  logic req_valid,
  input  logic req_wait,
  input  logic u0_run,
  output logic req_ready,
  output logic fire
);
  logic stall;
  assign stall     = req_wait && u0_run;
  assign req_ready = !stall;
  assign fire      = req_valid && !stall;
endmodule

// File: rtl/vcx_vec_file.sv
module vcx_vec_file #(
  parameter int IDX_W = 5,
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [VEC_W-1:0] wdata,
  output logic [VEC_W-1:0] rdata
);
  localparam int NREG = 1 << IDX_W;
  logic [VEC_W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we && idx != '0) begin
      regs[idx] <= wdata;
    end
  end

  assign rdata = (idx == '0) ? '0 : regs[idx];
endmodule

// File: rtl/vcx_ctrl_file.sv
module vcx_ctrl_file #(
  parameter int          IDX_W      = 5,
  parameter int          CTL_W      = 32,
  parameter int          PC_W       = 16,
  parameter int          IDX_MACF   = 16,
  parameter int          IDX_PC     = 26,
  parameter int          IDX_FBRST  = 28,
  parameter int          IDX_STAT   = 29,
  parameter int          IDX_START1 = 31,
  parameter logic [31:0] FB_KEEP    = 32'h0000_0C0C
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [CTL_W-1:0] wdata,
  input  logic             u0_run,
  input  logic             u1_run,
  output logic [CTL_W-1:0] rdata,
  output logic [3:0]       pulses,   // {u1_reset, u1_break, u0_reset, u0_break}
  output logic             u1_start,
  output logic [PC_W-1:0]  u1_pc
);
  localparam int NREG     = 1 << IDX_W;
  localparam int B_U0_BRK = 0;
  localparam int B_U0_RST = 1;
  localparam int B_U1_BRK = 8;
  localparam int B_U1_RST = 9;
  localparam int B_RUN0   = 0;
  localparam int B_RUN1   = 8;

  logic [CTL_W-1:0] regs [NREG];
  logic [CTL_W-1:0] status_val;
  logic is_ro, is_fb, is_st, wr_ok;

  always_comb begin
    status_val         = '0;
    status_val[B_RUN0] = u0_run;
    status_val[B_RUN1] = u1_run;
  end

  assign is_ro = (idx == IDX_W'(IDX_MACF)) || (idx == IDX_W'(IDX_PC)) ||
                 (idx == IDX_W'(IDX_STAT));
  assign is_fb = (idx == IDX_W'(IDX_FBRST));
  assign is_st = (idx == IDX_W'(IDX_START1));
  assign wr_ok = we && (idx != '0) && !is_ro;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      pulses   <= '0;
      u1_start <= 1'b0;
      u1_pc    <= '0;
    end else begin
      pulses   <= '0;
      u1_start <= 1'b0;
      if (wr_ok) begin
        if (is_fb) begin
          regs[idx] <= wdata & FB_KEEP[CTL_W-1:0];
          pulses    <= {wdata[B_U1_RST], wdata[B_U1_BRK],
                        wdata[B_U0_RST], wdata[B_U0_BRK]};
        end else if (is_st) begin
          if (!u1_run) begin
            u1_pc    <= wdata[PC_W-1:0];
            u1_start <= 1'b1;
          end
        end else begin
          regs[idx] <= wdata;
        end
      end
    end
  end

  assign rdata = (idx == IDX_W'(IDX_STAT)) ? status_val :
                 (idx == '0)              ? '0 : regs[idx];
endmodule

// File: rtl/vcx_xfer_unit.sv
module vcx_xfer_unit #(
  parameter int IDX_W = 5,
  parameter int VEC_W = 128,
  parameter int CTL_W = 32,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic             req_wait,
  input  logic [IDX_W-1:0] req_idx,
  input  logic [IDX_W-1:0] req_hreg,
  input  logic [VEC_W-1:0] req_data,
  output logic             rsp_valid,
  output logic             rsp_wen,
  output logic [IDX_W-1:0] rsp_hreg,
  output logic [VEC_W-1:0] rsp_data,
  input  logic             u0_run,
  input  logic             u1_run,
  output logic             u0_break,
  output logic             u0_reset,
  output logic             u1_break,
  output logic             u1_reset,
  output logic             u1_start,
  output logic [PC_W-1:0]  u1_pc,
  input  logic             br_on_true,
  output logic             cop_cond,
  output logic             br_taken,
  input  logic [31:0]      call_instr,
  output logic [17:0]      call_addr
);
  import vcx_pkg::*;

  xfer_op_e         op;
  logic             xfer_fire;
  logic [VEC_W-1:0] vec_rdata;
  logic [CTL_W-1:0] ctl_rdata;
  logic [3:0]       pulse_vec;
  logic [VEC_W-1:0] read_mux;

  assign op = xfer_op_e'(req_op);

  vcx_interlock u_lock (
    .req_valid (req_valid),
    .req_wait  (req_wait),
    .u0_run    (u0_run),
    .req_ready (req_ready),
    .fire      (xfer_fire)
  );

  vcx_vec_file #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_vec (
    .clk   (clk),
    .rst   (rst),
    .we    (xfer_fire && op == OP_VEC_WR),
    .idx   (req_idx),
    .wdata (req_data),
    .rdata (vec_rdata)
  );

  vcx_ctrl_file #(.IDX_W(IDX_W), .CTL_W(CTL_W), .PC_W(PC_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .we       (xfer_fire && op == OP_CTL_WR),
    .idx      (req_idx),
    .wdata    (req_data[CTL_W-1:0]),
    .u0_run   (u0_run),
    .u1_run   (u1_run),
    .rdata    (ctl_rdata),
    .pulses   (pulse_vec),
    .u1_start (u1_start),
    .u1_pc    (u1_pc)
  );

  assign {u1_reset, u1_break, u0_reset, u0_break} = pulse_vec;

  always_comb begin
    if (op == OP_CTL_RD) read_mux = {{(VEC_W-64){1'b0}}, widen_signed(ctl_rdata)};
    else                 read_mux = vec_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_wen   <= 1'b0;
      rsp_hreg  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= xfer_fire && is_read(op);
      if (xfer_fire && is_read(op)) begin
        rsp_wen  <= (req_hreg != '0);
        rsp_hreg <= req_hreg;
        rsp_data <= read_mux;
      end
    end
  end

  assign cop_cond  = u1_run;
  assign br_taken  = (cop_cond == br_on_true);
  assign call_addr = call_target(call_instr);
endmodule

// File: rtl/vcx_xfer_checker.sv
module vcx_xfer_checker #(
  parameter int IDX_W      = 5,
  parameter int VEC_W      = 128,
  parameter int IDX_FBRST  = 28,
  parameter int IDX_START1 = 31
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_wait,
  input logic [1:0]       req_op,
  input logic [IDX_W-1:0] req_idx,
  input logic [IDX_W-1:0] req_hreg,
  input logic [VEC_W-1:0] req_data,
  input logic             xfer_fire,
  input logic             rsp_valid,
  input logic             rsp_wen,
  input logic             u0_run,
  input logic             u1_run,
  input logic             u0_break,
  input logic             u1_reset,
  input logic             u1_start
);
  // R3
  interlock_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_wait && u0_run) |-> (!req_ready && !xfer_fire));

  // R3
  no_wait_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_wait) |-> xfer_fire);

  // R2
  rsp_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(xfer_fire && (req_op == 2'd1 || req_op == 2'd2)));

  // R5
  hreg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_wen) |-> ($past(req_hreg) != '0));

  // R8
  u0_break_src_chk: assert property (@(posedge clk) disable iff (rst)
    u0_break |-> $past(xfer_fire && req_op == 2'd3 &&
                       req_idx == IDX_W'(IDX_FBRST) && req_data[0]));

  // R8
  u1_reset_src_chk: assert property (@(posedge clk) disable iff (rst)
    u1_reset |-> $past(xfer_fire && req_op == 2'd3 &&
                       req_idx == IDX_W'(IDX_FBRST) && req_data[9]));

  // R9
  start_src_chk: assert property (@(posedge clk) disable iff (rst)
    u1_start |-> $past(xfer_fire && req_op == 2'd3 &&
                       req_idx == IDX_W'(IDX_START1) && !u1_run));
endmodule

bind vcx_xfer_unit vcx_xfer_checker #(.IDX_W(IDX_W), .VEC_W(VEC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_wait  (req_wait),
  .req_op    (req_op),
  .req_idx   (req_idx),
  .req_hreg  (req_hreg),
  .req_data  (req_data),
  .xfer_fire (xfer_fire),
  .rsp_valid (rsp_valid),
  .rsp_wen   (rsp_wen),
  .u0_run    (u0_run),
  .u1_run    (u1_run),
  .u0_break  (u0_break),
  .u1_reset  (u1_reset),
  .u1_start  (u1_start)
);

// File: tb/vcx_xfer_unit_bench.sv
`timescale 1ns/1ps
module vcx_xfer_unit_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_wait = 1'b0;
  logic [1:0]   req_op = 2'd0;
  logic [4:0]   req_idx = '0, req_hreg = '0;
  logic [127:0] req_data = '0;
  logic         u0_run = 1'b0, u1_run = 1'b0, br_on_true = 1'b0;
  logic [31:0]  call_instr = '0;
  logic         req_ready, rsp_valid, rsp_wen;
  logic [4:0]   rsp_hreg;
  logic [127:0] rsp_data;
  logic         u0_break, u0_reset, u1_break, u1_reset, u1_start, cop_cond, br_taken;
  logic [15:0]  u1_pc;
  logic [17:0]  call_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [133:0] exp_q [$];   // {wen, hreg, data}
  string        tag_q [$];

  always #5 clk = ~clk;

  vcx_xfer_unit u_vcx_xfer_unit (.*);

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk("R2 unexpected response", 128'd1, 128'd0);
      end else begin
        logic [133:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({t, " data"}, rsp_data, e[127:0]);
        chk({t, " hreg/wen"}, {122'd0, rsp_wen, rsp_hreg}, {122'd0, e[133:128]});
      end
    end
  end

  // driver: issues one transfer; for reads pushes the expected response
  task automatic xfer(input logic [1:0] op, input logic [4:0] idx, input logic [4:0] hreg,
                      input logic [127:0] data, input logic wt,
                      input logic [127:0] exp_data, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_idx = idx; req_hreg = hreg;
    req_data = data; req_wait = wt;
    #1;
    while (!req_ready) @(negedge clk);
    if (op == 2'd1 || op == 2'd2) begin
      exp_q.push_back({(hreg != 5'd0), hreg, exp_data});
      tag_q.push_back(tag);
    end
    @(negedge clk);
    req_valid = 1'b0; req_wait = 1'b0;
  endtask

  function automatic logic [127:0] cext(input logic [31:0] v);
    logic [127:0] r;
    r = '0;
    r[31:0] = v;
    for (int i = 32; i < 64; i++) r[i] = v[31];
    return r;
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outputs", {120'd0, rsp_valid, req_ready, u0_break, u0_reset, u1_break, u1_reset, u1_start, 1'b0},
        {120'd0, 1'b0, 1'b1, 6'd0});
    chk("R1 u1_pc", {112'd0, u1_pc}, 128'd0);
    xfer(2'd1, 5'd5, 5'd3, '0, 1'b0, 128'd0, "R1 vec reset");
    xfer(2'd2, 5'd7, 5'd3, '0, 1'b0, 128'd0, "R1 ctl reset");

    // R2 vector moves, several patterns
    xfer(2'd0, 5'd5, 5'd0, {128{1'b1}}, 1'b0, '0, "");
    xfer(2'd0, 5'd6, 5'd0, {32{4'hA}}, 1'b0, '0, "");
    xfer(2'd0, 5'd31, 5'd0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, 1'b0, '0, "");
    xfer(2'd1, 5'd5, 5'd1, '0, 1'b0, {128{1'b1}}, "R2 ones");
    xfer(2'd1, 5'd6, 5'd2, '0, 1'b0, {32{4'hA}}, "R2 alt");
    xfer(2'd1, 5'd31, 5'd30, '0, 1'b0, 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210, "R2 distinct");

    // R5 index 0 and host dest 0
    xfer(2'd0, 5'd0, 5'd0, {128{1'b1}}, 1'b0, '0, "");
    xfer(2'd1, 5'd0, 5'd4, '0, 1'b0, 128'd0, "R5 vec idx0");
    xfer(2'd3, 5'd0, 5'd0, 128'hFFFF_FFFF, 1'b0, '0, "");
    xfer(2'd2, 5'd0, 5'd4, '0, 1'b0, 128'd0, "R5 ctl idx0");
    xfer(2'd1, 5'd5, 5'd0, '0, 1'b0, {128{1'b1}}, "R5 hreg0 wen");

    // R4 / R10 sign fill and full-width store
    xfer(2'd3, 5'd3, 5'd0, {96'hFFFF, 32'h8000_1234}, 1'b0, '0, "");
    xfer(2'd3, 5'd4, 5'd0, 128'h7FFF_0001, 1'b0, '0, "");
    xfer(2'd2, 5'd3, 5'd9, '0, 1'b0, cext(32'h8000_1234), "R4 R10 neg");
    xfer(2'd2, 5'd4, 5'd9, '0, 1'b0, cext(32'h7FFF_0001), "R4 R10 pos");

    // R6 read-only registers
    xfer(2'd3, 5'd16, 5'd0, 128'hDEAD_BEEF, 1'b0, '0, "");
    xfer(2'd3, 5'd26, 5'd0, 128'h1234_5678, 1'b0, '0, "");
    xfer(2'd3, 5'd29, 5'd0, 128'hFFFF_FFFF, 1'b0, '0, "");
    xfer(2'd2, 5'd16, 5'd8, '0, 1'b0, 128'd0, "R6 macflag");
    xfer(2'd2, 5'd26, 5'd8, '0, 1'b0, 128'd0, "R6 pc");
    u1_run = 1'b1;
    xfer(2'd2, 5'd29, 5'd8, '0, 1'b0, 128'h100, "R6 status");
    u1_run = 1'b0;

    // R7 / R8 break/reset register
    xfer(2'd3, 5'd28, 5'd0, 128'hFFFF_FFFF, 1'b0, '0, "");
    chk("R8 all pulses", {124'd0, u1_reset, u1_break, u0_reset, u0_break}, 128'hF);
    @(negedge clk);
    chk("R8 pulse one cycle", {124'd0, u1_reset, u1_break, u0_reset, u0_break}, 128'h0);
    xfer(2'd2, 5'd28, 5'd8, '0, 1'b0, 128'h0C0C, "R7 mask");
    xfer(2'd3, 5'd28, 5'd0, 128'h2, 1'b0, '0, "");
    chk("R8 u0 reset only", {124'd0, u1_reset, u1_break, u0_reset, u0_break}, 128'h2);
    xfer(2'd3, 5'd28, 5'd0, 128'h100, 1'b0, '0, "");
    chk("R8 u1 break only", {124'd0, u1_reset, u1_break, u0_reset, u0_break}, 128'h4);
    xfer(2'd2, 5'd28, 5'd8, '0, 1'b0, 128'h0, "R7 masked off");

    // R9 start of unit 1
    xfer(2'd3, 5'd31, 5'd0, 128'hABCD_1234, 1'b0, '0, "");
    chk("R9 start pulse", {127'd0, u1_start}, 128'd1);
    chk("R9 pc", {112'd0, u1_pc}, 128'h1234);
    u1_run = 1'b1;
    xfer(2'd3, 5'd31, 5'd0, 128'h5555, 1'b0, '0, "");
    chk("R9 busy no start", {127'd0, u1_start}, 128'd0);
    chk("R9 busy pc kept", {112'd0, u1_pc}, 128'h1234);
    u1_run = 1'b0;
    xfer(2'd2, 5'd31, 5'd8, '0, 1'b0, 128'd0, "R9 not stored");

    // R3 interlock
    @(negedge clk);
    u0_run = 1'b1;
    req_valid = 1'b1; req_op = 2'd0; req_idx = 5'd9; req_hreg = 5'd0;
    req_data = 128'h55; req_wait = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk("R3 stalled ready", {127'd0, req_ready}, 128'd0);
      @(negedge clk);
    end
    u0_run = 1'b0;
    #1;
    chk("R3 released ready", {127'd0, req_ready}, 128'd1);
    @(negedge clk);
    req_valid = 1'b0; req_wait = 1'b0;
    xfer(2'd1, 5'd9, 5'd1, '0, 1'b0, 128'h55, "R3 write landed");
    u0_run = 1'b1;
    xfer(2'd1, 5'd9, 5'd1, '0, 1'b0, 128'h55, "R3 no wait passes");
    u0_run = 1'b0;

    // R11 branch condition
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      u1_run = c[0]; br_on_true = c[1];
      #1;
      chk("R11 cond", {127'd0, cop_cond}, {127'd0, c[0]});
      chk("R11 taken", {127'd0, br_taken}, {127'd0, (c[0] == c[1])});
    end
    u1_run = 1'b0;

    // R12 call address
    call_instr = 32'hFFFF_FFFF;
    #1 chk("R12 max field", {110'd0, call_addr}, 128'h3FFF8);
    call_instr = 32'h0000_0040;
    #1 chk("R12 one", {110'd0, call_addr}, 128'd8);
    call_instr = 32'hFFE0_003F;
    #1 chk("R12 outside bits", {110'd0, call_addr}, 128'd0);

    repeat (3) @(negedge clk);
    chk("R2 queue drained", 128'(exp_q.size()), 128'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule